// File: doc/BRIEF.md
# Texel format decode unit

This unit turns one raw 32-bit texel word, tagged with a format code, into four channel values that a filter stage can use directly. Every lane leaves the unit in one shared signed fixed-point format with two integer bits and sixteen fraction bits. In this format 1.0 is 65536 and -1.0 is -65536. Normalised unsigned, normalised signed and sRGB-encoded storage all end up in that one form. Later stages therefore never have to rescale or re-linearise a channel.

The unit is a two-stage pipeline and takes a new texel on every clock.

- **Stage 1** looks at the format code and cuts the word into per-lane codes, each tagged with a conversion kind.
- **Stage 2** applies the reciprocal scaling, the sign handling or the sRGB lookup, and registers the result.

Channels always appear in the order they are stored. A blue-first texel is not reordered: its blue byte comes out on lane x.

Top module: `texdec_top`

## Requirements
- R1: Format code 0 (four 8-bit unsigned normalised channels) decodes as follows. Byte k of the word (bits 8k+7..8k) goes to lane k, with lanes x, y, z, w = 0..3. Each byte v becomes round(v*65536/255), so 0 gives 0 and 255 gives 65536.
- R2: Format code 1 (blue-first 8-bit unsigned normalised) uses the same scaling as R1 and no reordering. Lane x carries bits 7..0 (blue) and lane z carries bits 23..16 (red).
- R3: Format code 2 (8-bit sRGB) maps bytes 0..2 to linear values on lanes x, y and z. Byte 3 is scaled linearly as in R1 onto lane w. The linear value is round(65536*L). L is c/12.92 when c <= 0.04045, and ((c+0.055)/1.055)^2.4 otherwise, with c = v/255.
- R4: Format code 3 (16-bit single-channel unsigned normalised) takes bits 15..0 as v and gives lane x = round(v*65536/65535). Lanes y and z are 0 and lane w is 65536. Bits 31..16 have no effect on any lane.
- R5: Format code 4 (8-bit signed normalised) treats each byte k as a two's-complement value s and gives lane k = round(s*65536/127). Code -128 clamps to -65536, the same as -127.
- R6: Format codes 5, 6 and 7 are reserved and give 0 on all four lanes.
- R7: A texel accepted with in_valid high on a rising edge appears with out_valid high after exactly the second rising edge. out_valid is low two edges after an edge where in_valid was low. Texels may arrive on every cycle.
- R8: While reset is asserted, out_valid and all four lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A texel is presented this cycle |
| in_word | input | 32 | Raw texel word as stored |
| in_fmt | input | 3 | Storage format code |
| out_valid | output | 1 | Lanes hold a decoded texel |
| out_x | output | 18 | Lane 0, signed 2.16 fixed point |
| out_y | output | 18 | Lane 1, signed 2.16 fixed point |
| out_z | output | 18 | Lane 2, signed 2.16 fixed point |
| out_w | output | 18 | Lane 3, signed 2.16 fixed point |

## Verification
Each decoded texel and its valid strobe show up two rising edges after the edge that took the input, and the idle state also follows two edges later. The bench drives each input on a falling edge and computes the expected lanes at once. It holds the expected results in a two-deep history, shifted once per falling edge, and compares on the falling edge two cycles after the drive. Valid is compared on every cycle; the four lanes are compared only when a texel is expected. This holds for back-to-back texels as well as with gaps, so the comparison can never drift from the pipeline.

// File: rtl/texdec_pkg.sv
package texdec_pkg;
    localparam int LANES   = 4;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = LANES * BYTE_W;
    localparam int CODE_W  = 2 * BYTE_W;
    localparam int FRAC_W  = 16;
    localparam int VAL_W   = FRAC_W + 2;
    localparam int FMT_W   = 3;

    typedef logic [FMT_W-1:0] fmt_t;
    localparam fmt_t FMT_RGBA8  = 3'd0;
    localparam fmt_t FMT_BGRA8  = 3'd1;
    localparam fmt_t FMT_SRGB8  = 3'd2;
    localparam fmt_t FMT_R16    = 3'd3;
    localparam fmt_t FMT_SNORM8 = 3'd4;

    typedef logic signed [VAL_W-1:0] val_t;
    localparam val_t VAL_ONE = val_t'(1 << FRAC_W);

    typedef enum logic [2:0] {
        KIND_ZERO = 3'd0,
        KIND_ONE  = 3'd1,
        KIND_UN8  = 3'd2,
        KIND_UN16 = 3'd3,
        KIND_SRGB = 3'd4,
        KIND_SN8  = 3'd5
    } kind_t;

    typedef struct packed {
        kind_t             kind;
        logic [CODE_W-1:0] code;
    } lane_t;
endpackage

// File: rtl/texdec_unpack.sv
module texdec_unpack
    import texdec_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  fmt_t               fmt,
    output lane_t [LANES-1:0]  lanes
);
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lanes[i].code = CODE_W'(word[BYTE_W*i +: BYTE_W]);
            case (fmt)
                FMT_RGBA8, FMT_BGRA8: lanes[i].kind = KIND_UN8;
                FMT_SRGB8:  lanes[i].kind = (i == LANES-1) ? KIND_UN8 : KIND_SRGB;
                FMT_SNORM8: lanes[i].kind = KIND_SN8;
                FMT_R16: begin
                    if (i == 0) begin
                        lanes[i].kind = KIND_UN16;
                        lanes[i].code = word[CODE_W-1:0];
                    end else if (i == LANES-1) begin
                        lanes[i].kind = KIND_ONE;
                    end else begin
                        lanes[i].kind = KIND_ZERO;
                    end
                end
                default: lanes[i].kind = KIND_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/texdec_srgb_lut.sv
module texdec_srgb_lut
    import texdec_pkg::*;
(
    input  logic [BYTE_W-1:0] idx,
    output val_t              lin
);
    localparam int ENTRIES = 1 << BYTE_W;

    function automatic val_t srgb_point(int code);
        real c;
        real l;
        c = real'(code) / real'(ENTRIES - 1);
        if (c <= 0.04045) l = c / 12.92;
        else              l = ((c + 0.055) / 1.055) ** 2.4;
        return val_t'($rtoi(l * (2.0 ** FRAC_W) + 0.5));
    endfunction

    val_t table_w [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam val_t PT = srgb_point(g);
        assign table_w[g] = PT;
    end

    assign lin = table_w[idx];
endmodule

// File: rtl/texdec_chan.sv
module texdec_chan
    import texdec_pkg::*;
(
    input  lane_t lane,
    output val_t  val
);
    localparam int          SH     = 40;
    localparam int          SN_MAX = (1 << (BYTE_W-1)) - 1;
    localparam logic [63:0] BIG    = 64'd1 << (FRAC_W + SH);
    localparam logic [63:0] M8     = 64'((1 << BYTE_W) - 1);
    localparam logic [63:0] M16    = 64'((1 << CODE_W) - 1);
    localparam logic [63:0] M7     = 64'(SN_MAX);
    localparam logic [63:0] RCP8   = (BIG + M8 / 2) / M8;
    localparam logic [63:0] RCP16  = (BIG + M16 / 2) / M16;
    localparam logic [63:0] RCP7   = (BIG + M7 / 2) / M7;

    function automatic val_t scale(logic [CODE_W-1:0] c, logic [63:0] rcp);
        logic [63:0] p;
        p = 64'(c) * rcp + (64'd1 << (SH-1));
        return val_t'(p >> SH);
    endfunction

    val_t              lut_val;
    val_t              un8_val;
    val_t              sn_mag;
    logic [BYTE_W-1:0] mag8;

    texdec_srgb_lut u_lut (
        .idx (lane.code[BYTE_W-1:0]),
        .lin (lut_val)
    );

    always_comb begin
        un8_val = scale(CODE_W'(lane.code[BYTE_W-1:0]), RCP8);
        mag8    = lane.code[BYTE_W-1] ? (BYTE_W'(0) - lane.code[BYTE_W-1:0])
                                      : lane.code[BYTE_W-1:0];
        if (mag8 > BYTE_W'(SN_MAX)) mag8 = BYTE_W'(SN_MAX);
        sn_mag  = scale(CODE_W'(mag8), RCP7);
        case (lane.kind)
            KIND_ONE:  val = VAL_ONE;
            KIND_UN8:  val = un8_val;
            KIND_UN16: val = scale(lane.code, RCP16);
            KIND_SRGB: val = lut_val;
            KIND_SN8:  val = lane.code[BYTE_W-1] ? -sn_mag : sn_mag;
            default:   val = '0;
        endcase
        if (lane.kind == KIND_SRGB) begin
            AST_SRGB_BELOW: assert (lut_val >= 0 && lut_val <= un8_val); // R3
        end
    end
endmodule

// File: rtl/texdec_top.sv
module texdec_top
    import texdec_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [31:0]             in_word,
    input  logic [2:0]              in_fmt,
    output logic                    out_valid,
    output logic signed [17:0]      out_x,
    output logic signed [17:0]      out_y,
    output logic signed [17:0]      out_z,
    output logic signed [17:0]      out_w
);
    typedef struct packed {
        logic              vld;
        fmt_t              fmt;
        lane_t [LANES-1:0] lanes;
    } s1_t;

    typedef struct packed {
        logic             vld;
        fmt_t             fmt;
        val_t [LANES-1:0] vals;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } st_t;

    st_t               st_d;
    st_t               st_q;
    lane_t [LANES-1:0] unp_lanes;
    val_t              conv_vals [LANES];

    texdec_unpack u_unpack (
        .word  (in_word),
        .fmt   (in_fmt),
        .lanes (unp_lanes)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_chan
        texdec_chan u_chan (
            .lane (st_q.s1.lanes[g]),
            .val  (conv_vals[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.s1.vld   = in_valid;
        st_d.s1.fmt   = in_fmt;
        st_d.s1.lanes = unp_lanes;
        st_d.s2.vld   = st_q.s1.vld;
        st_d.s2.fmt   = st_q.s1.fmt;
        for (int i = 0; i < LANES; i++) begin
            st_d.s2.vals[i] = conv_vals[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.s2.vld;
    assign out_x     = st_q.s2.vals[0];
    assign out_y     = st_q.s2.vals[1];
    assign out_z     = st_q.s2.vals[2];
    assign out_w     = st_q.s2.vals[3];

    AST_VALID_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R7
    AST_IDLE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid); // R7
    AST_UNORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (st_q.s2.fmt == FMT_RGBA8 || st_q.s2.fmt == FMT_BGRA8))
        |-> (out_x >= 0 && out_x <= VAL_ONE && out_y >= 0 && out_y <= VAL_ONE &&
             out_z >= 0 && out_z <= VAL_ONE && out_w >= 0 && out_w <= VAL_ONE)); // R1
    AST_SNORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.s2.fmt == FMT_SNORM8)
        |-> (out_x >= -VAL_ONE && out_x <= VAL_ONE && out_y >= -VAL_ONE && out_y <= VAL_ONE &&
             out_z >= -VAL_ONE && out_z <= VAL_ONE && out_w >= -VAL_ONE && out_w <= VAL_ONE)); // R5
    AST_R16_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.s2.fmt == FMT_R16)
        |-> (out_y == 0 && out_z == 0 && out_w == VAL_ONE && out_x >= 0)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q.s2.fmt > FMT_SNORM8)
        |-> (out_x == 0 && out_y == 0 && out_z == 0 && out_w == 0)); // R6
endmodule

// File: tb/texdec_top_test.sv
module texdec_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [31:0]       in_word = '0;
    logic [2:0]        in_fmt = '0;
    logic              out_valid;
    logic signed [17:0] out_x, out_y, out_z, out_w;

    int n_cmp = 0;
    int n_bad = 0;

    logic hv [2];
    logic [2:0] hf [2];
    int   he [2][4];

    texdec_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_fmt(in_fmt), .out_valid(out_valid), .out_x(out_x), .out_y(out_y),
        .out_z(out_z), .out_w(out_w)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int unorm_e(longint v, longint m);
        return int'((v * 65536 + m / 2) / m);
    endfunction

    function automatic int srgb_e(int v);
        real c;
        real l;
        c = real'(v) / 255.0;
        if (c <= 0.04045) l = c / 12.92;
        else              l = ((c + 0.055) / 1.055) ** 2.4;
        return $rtoi(l * 65536.0 + 0.5);
    endfunction

    function automatic int snorm_e(logic [7:0] b);
        int s;
        int m;
        int e;
        s = int'($signed(b));
        m = (s < 0) ? -s : s;
        if (m > 127) m = 127;
        e = (m * 65536 + 63) / 127;
        return (s < 0) ? -e : e;
    endfunction

    function automatic int expect_lane(logic [2:0] f, logic [31:0] w, int k);
        logic [7:0] b;
        b = w[8*k +: 8];
        case (f)
            3'd0, 3'd1: return unorm_e(longint'(b), 255);
            3'd2: return (k < 3) ? srgb_e(int'(b)) : unorm_e(longint'(b), 255);
            3'd3: begin
                if (k == 0) return unorm_e(longint'(w[15:0]), 65535);
                if (k == 3) return 65536;
                return 0;
            end
            3'd4: return snorm_e(b);
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic compare_now();
        int got [4];
        got[0] = int'(out_x); got[1] = int'(out_y);
        got[2] = int'(out_z); got[3] = int'(out_w);
        n_cmp++;
        if (out_valid !== hv[1]) begin
            n_bad++;
            $display("FAIL R7 out_valid actual %0b expected %0b", out_valid, hv[1]);
        end
        if (hv[1]) begin
            for (int k = 0; k < 4; k++) begin
                n_cmp++;
                if (got[k] != he[1][k]) begin
                    n_bad++;
                    $display("FAIL %s fmt %0d lane %0d actual %0d expected %0d",
                             tag_of(hf[1]), hf[1], k, got[k], he[1][k]);
                end
            end
        end
    endtask

    task automatic step(logic v, logic [2:0] f, logic [31:0] w);
        compare_now();
        hv[1] = hv[0]; hf[1] = hf[0];
        for (int k = 0; k < 4; k++) he[1][k] = he[0][k];
        hv[0] = v; hf[0] = f;
        for (int k = 0; k < 4; k++) he[0][k] = expect_lane(f, w, k);
        in_valid = v; in_fmt = f; in_word = w;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 2; i++) begin
            hv[i] = 1'b0; hf[i] = '0;
            for (int k = 0; k < 4; k++) he[i][k] = 0;
        end
        repeat (3) @(negedge clk);
        // R8: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || out_x !== 0 || out_y !== 0 || out_z !== 0 || out_w !== 0) begin
            n_bad++;
            $display("FAIL R8 reset outputs actual %0b %0d %0d %0d %0d expected 0 0 0 0 0",
                     out_valid, out_x, out_y, out_z, out_w);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1 extremes, R2 storage order
        step(1, 3'd0, 32'hFF00_80FF);
        step(1, 3'd0, 32'h0001_FE7F);
        step(1, 3'd1, 32'h1122_3344);
        step(1, 3'd1, 32'hFF00_00FF);
        // R3 around the curve break and ends
        step(1, 3'd2, 32'h800B_0A00);
        step(1, 3'd2, 32'h00FF_8001);
        // R4 ends and ignored upper half
        step(1, 3'd3, 32'hDEAD_FFFF);
        step(1, 3'd3, 32'h0000_0000);
        step(1, 3'd3, 32'hFFFF_8000);
        step(1, 3'd3, 32'h1234_7FFF);
        // R5 clamp and extremes
        step(1, 3'd4, 32'h0081_7F80);
        step(1, 3'd4, 32'hC040_01FF);
        // R6 reserved codes
        step(1, 3'd5, 32'hFFFF_FFFF);
        step(1, 3'd6, 32'h1234_5678);
        step(1, 3'd7, 32'h8080_8080);
        // R7 gaps between texels
        step(0, 3'd0, 32'hFFFF_FFFF);
        step(1, 3'd4, 32'h0000_0080);
        step(0, 3'd2, 32'h0);
        step(0, 3'd2, 32'h0);
        step(1, 3'd1, 32'h00FF_0000);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 4) != 0, 3'($urandom % 8), $urandom);
        end
        step(0, 3'd0, 32'h0);
        step(0, 3'd0, 32'h0);
        step(0, 3'd0, 32'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule